// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block owns the instruction address of a 32-bit processor with 32-bit instruction words. On each instruction step it reads the 6-bit opcode and the 16-bit immediate of the current instruction, together with the zero flag from the datapath. From these it picks the next program counter. It covers sequential advance, absolute and PC-relative unconditional jumps, conditional jumps on the zero flag in both addressing forms, and subroutine call and return. Call and return go through an internal hardware return-address stack.

The PC counts instruction words, so a sequential advance adds one. A call pushes the address of the instruction after it. A return pops that address back into the PC. A stack overflow or underflow raises an error flag that stays set until reset, and the offending instruction leaves the PC where it is. Execution stops in two cases: a halt instruction, or a halt request on the dedicated input. Once stopped, the PC stays frozen until the next reset.

Top module: `pcu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the PC becomes 0, the return stack becomes empty and `stack_err` becomes 0.
- R2: A clock edge with `step` low leaves the PC and the return stack unchanged.
- R3: A step with opcode 6 loads the PC with the immediate zero-extended to 32 bits.
- R4: A step with opcode 7 sets the PC to the PC plus the sign-extended immediate, modulo 2^32.
- R5: Opcodes 8 (absolute) and 9 (relative) jump as in R3/R4 when `zero_flag` is 1. When it is 0, the PC advances by one.
- R6: Opcodes 10 (absolute) and 11 (relative) jump as in R3/R4 when `zero_flag` is 0. When it is 1, the PC advances by one.
- R7: Opcode 12 pushes PC+1 on the 8-entry return stack and loads the PC with the zero-extended immediate. Opcode 13 pops the newest entry into the PC, so returns come back in last-in, first-out order.
- R8: Opcode 12 with 8 entries already on the stack sets `stack_err`, keeps the PC and leaves the stack contents intact.
- R9: Opcode 13 with an empty stack sets `stack_err` and keeps the PC. `stack_err` stays 1 until reset.
- R10: A step with opcode 34 keeps the PC. After it, all steps are ignored until reset.
- R11: A clock edge with `halt_in` high keeps the PC. After it, all steps are ignored until reset, even once `halt_in` falls.
- R12: Every other opcode (including 33 and 0..5, 14..32, 35..63) advances the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Execute the presented instruction on this edge |
| opcode | input | 6 | Opcode of the current instruction |
| imm | input | 16 | Immediate field of the current instruction |
| zero_flag | input | 1 | Zero flag from the datapath |
| halt_in | input | 1 | External halt request |
| pc | output | 32 | Current program counter (word address) |
| stack_err | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
The checker watches several properties on every cycle. It confirms that the PC holds when there is no step, when stopped and on a halt request. It checks the absolute and zero-conditioned jump targets, and that an overflowing call or underflowing return freezes the PC and raises the error. It also checks that the error flag is sticky and that the stack occupancy never exceeds its depth. Other properties need a history longer than one edge, and only the bench scenarios can show them. These are the last-in, first-out ordering of return addresses over a full stack, that a rejected push corrupts no saved entry, the relative wrap-around arithmetic, and that stepping stays dead after a halt until reset.

// File: rtl/pcu_pkg.sv
// Package: shared widths and opcode values for the program counter unit.
// Assumes a fixed 6-bit opcode field; opcode values are decoded by the
// instruction stream and must not be reassigned.
package pcu_pkg;
    parameter int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JMP_ABS  = 6'd6;
    localparam logic [OPC_W-1:0] OPC_JMP_REL  = 6'd7;
    localparam logic [OPC_W-1:0] OPC_JZ_ABS   = 6'd8;
    localparam logic [OPC_W-1:0] OPC_JZ_REL   = 6'd9;
    localparam logic [OPC_W-1:0] OPC_JNZ_ABS  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_JNZ_REL  = 6'd11;
    localparam logic [OPC_W-1:0] OPC_CALL     = 6'd12;
    localparam logic [OPC_W-1:0] OPC_RET      = 6'd13;
    localparam logic [OPC_W-1:0] OPC_NOP      = 6'd33;
    localparam logic [OPC_W-1:0] OPC_HALT     = 6'd34;
endpackage

// File: rtl/pcu_ret_stack.sv
// Module: pcu_ret_stack
// Return-address LIFO of DEPTH entries held in flops. Assumes the caller
// never asserts push when full, pop when empty, or both at once; the
// branch decoder guarantees this. top_data is valid only when not empty.
module pcu_ret_stack #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_data,
    output logic [ADDR_W-1:0] top_data,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);
    logic [ADDR_W-1:0] slot [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  top_idx;

    // Occupancy counter: up on push, down on pop, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push)
            cnt_q <= cnt_q + CNT_W'(1);
        else if (pop)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // One storage entry per depth position; written only when it is the next free slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (push && cnt_q == CNT_W'(i))
                slot[i] <= push_data;
        end
    end

    // Read port: newest entry sits one below the occupancy count.
    always_comb begin
        top_idx  = PTR_W'(cnt_q - CNT_W'(1));
        top_data = slot[top_idx];
    end

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign count = cnt_q;
endmodule

// File: rtl/pcu_next_pc.sv
// Module: pcu_next_pc
// Combinational branch decoder: from the current PC, opcode, immediate,
// zero flag and stack status it selects the next PC and the stack action.
// Assumes the PC is a word address, so the fall-through target is PC+1.
module pcu_next_pc
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic              zero_flag,
    input  logic              stk_full,
    input  logic              stk_empty,
    input  logic [ADDR_W-1:0] stk_top,
    output logic [ADDR_W-1:0] nxt_pc,
    output logic [ADDR_W-1:0] link_addr,
    output logic              do_push,
    output logic              do_pop,
    output logic              err_evt,
    output logic              halt_op
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] abs_tgt;
    logic [ADDR_W-1:0] rel_tgt;

    // Target arithmetic shared by all jump forms.
    always_comb begin
        link_addr = cur_pc + ADDR_W'(1);
        abs_tgt   = {{EXT_W{1'b0}}, imm};
        rel_tgt   = cur_pc + {{EXT_W{imm[IMM_W-1]}}, imm};
    end

    // Opcode decode: pick next PC and stack action.
    always_comb begin
        nxt_pc  = link_addr;
        do_push = 1'b0;
        do_pop  = 1'b0;
        err_evt = 1'b0;
        halt_op = 1'b0;
        case (opcode)
            OPC_JMP_ABS: nxt_pc = abs_tgt;
            OPC_JMP_REL: nxt_pc = rel_tgt;
            OPC_JZ_ABS:  if (zero_flag)  nxt_pc = abs_tgt;
            OPC_JZ_REL:  if (zero_flag)  nxt_pc = rel_tgt;
            OPC_JNZ_ABS: if (!zero_flag) nxt_pc = abs_tgt;
            OPC_JNZ_REL: if (!zero_flag) nxt_pc = rel_tgt;
            OPC_CALL: begin
                if (stk_full) begin
                    err_evt = 1'b1;
                    nxt_pc  = cur_pc;
                end else begin
                    do_push = 1'b1;
                    nxt_pc  = abs_tgt;
                end
            end
            OPC_RET: begin
                if (stk_empty) begin
                    err_evt = 1'b1;
                    nxt_pc  = cur_pc;
                end else begin
                    do_pop = 1'b1;
                    nxt_pc = stk_top;
                end
            end
            OPC_HALT: begin
                halt_op = 1'b1;
                nxt_pc  = cur_pc;
            end
            default: nxt_pc = link_addr;
        endcase
    end
endmodule

// File: rtl/pcu_top.sv
// Module: pcu_top
// Program counter and branch unit. On each qualified step it commits the
// next PC chosen by pcu_next_pc and drives the return stack. Assumes inputs
// are stable around the clock edge on which step is high. Halt (opcode or
// input) and the stack error are sticky until synchronous reset.
module pcu_top
    import pcu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 16,
    parameter int RS_DEPTH = 8,
    localparam int CNT_W   = $clog2(RS_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic              zero_flag,
    input  logic              halt_in,
    output logic [ADDR_W-1:0] pc,
    output logic              stack_err
);
    logic [ADDR_W-1:0] pc_q;
    logic              halted_q;
    logic              err_q;
    logic              live;
    logic [ADDR_W-1:0] nxt_pc;
    logic [ADDR_W-1:0] link_addr;
    logic [ADDR_W-1:0] stk_top;
    logic              dec_push, dec_pop, err_evt, halt_op;
    logic              stk_full, stk_empty;
    logic [CNT_W-1:0]  stk_count;

    // Qualify the step: no action while stopped or while a halt is requested.
    assign live = step && !halted_q && !halt_in;

    pcu_next_pc #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_dec (
        .cur_pc    (pc_q),
        .opcode    (opcode),
        .imm       (imm),
        .zero_flag (zero_flag),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .stk_top   (stk_top),
        .nxt_pc    (nxt_pc),
        .link_addr (link_addr),
        .do_push   (dec_push),
        .do_pop    (dec_pop),
        .err_evt   (err_evt),
        .halt_op   (halt_op)
    );

    pcu_ret_stack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (RS_DEPTH)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (live && dec_push),
        .pop       (live && dec_pop),
        .push_data (link_addr),
        .top_data  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty),
        .count     (stk_count)
    );

    // PC, sticky halt and sticky stack-error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (halt_in) begin
            halted_q <= 1'b1;
        end else if (live) begin
            pc_q <= nxt_pc;
            if (err_evt) err_q    <= 1'b1;
            if (halt_op) halted_q <= 1'b1;
        end
    end

    assign pc        = pc_q;
    assign stack_err = err_q;
endmodule

// File: rtl/pcu_checker.sv
// Module: pcu_checker
// Cycle-level properties of pcu_top, attached by bind. Observes ports and
// the qualified-step, halt and stack-status nets of the top module.
module pcu_checker
    import pcu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 16,
    parameter int RS_DEPTH = 8,
    localparam int CNT_W   = $clog2(RS_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic [OPC_W-1:0]  opcode,
    input logic [IMM_W-1:0]  imm,
    input logic              zero_flag,
    input logic              halt_in,
    input logic [ADDR_W-1:0] pc,
    input logic              stack_err,
    input logic              halted,
    input logic              live,
    input logic              stk_full,
    input logic              stk_empty,
    input logic [CNT_W-1:0]  stk_count
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0 && !stack_err && stk_count == '0));

    assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc));

    assert_abs_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && opcode == OPC_JMP_ABS) |=> pc == {{(ADDR_W-IMM_W){1'b0}}, $past(imm)});

    assert_jz_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live && opcode == OPC_JZ_ABS && zero_flag) |=> pc == {{(ADDR_W-IMM_W){1'b0}}, $past(imm)});

    assert_call_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && opcode == OPC_CALL && stk_full) |=> (stack_err && $stable(pc)));

    assert_ret_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live && opcode == OPC_RET && stk_empty) |=> (stack_err && $stable(pc)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && halted));

    assert_halt_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_in |=> ($stable(pc) && halted));

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stk_count <= CNT_W'(RS_DEPTH));
endmodule

bind pcu_top pcu_checker #(
    .ADDR_W   (ADDR_W),
    .IMM_W    (IMM_W),
    .RS_DEPTH (RS_DEPTH)
) u_pcu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .opcode    (opcode),
    .imm       (imm),
    .zero_flag (zero_flag),
    .halt_in   (halt_in),
    .pc        (pc),
    .stack_err (stack_err),
    .halted    (halted_q),
    .live      (live),
    .stk_full  (stk_full),
    .stk_empty (stk_empty),
    .stk_count (stk_count)
);

// File: tb/pcu_top_bench.sv
`timescale 1ns/1ps
// Bench for pcu_top: seeded random instruction steps mixed with directed
// stack, halt and reset corner cases, checked against a bench-side model.
module pcu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [5:0]  opcode = '0;
    logic [15:0] imm = '0;
    logic        zero_flag = 1'b0;
    logic        halt_in = 1'b0;
    logic [31:0] pc;
    logic        stack_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model state
    logic [31:0] m_pc;
    logic [31:0] m_stk [8];
    int          m_cnt;
    logic        m_err;
    logic        m_halt;

    always #10 clk = ~clk;

    pcu_top u_pcu_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .opcode    (opcode),
        .imm       (imm),
        .zero_flag (zero_flag),
        .halt_in   (halt_in),
        .pc        (pc),
        .stack_err (stack_err)
    );

    function automatic logic [31:0] zx(input logic [15:0] v);
        return {16'h0000, v};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic string tag_of(input logic [5:0] op, input logic stp);
        if (!stp) return "R2";
        case (op)
            6'd6: return "R3";
            6'd7: return "R4";
            6'd8, 6'd9: return "R5";
            6'd10, 6'd11: return "R6";
            6'd12: return (m_cnt == 8) ? "R8" : "R7";
            6'd13: return (m_cnt == 0) ? "R9" : "R7";
            6'd34: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] exp_pc, input logic exp_err);
        total++;
        if (pc !== exp_pc) begin
            bad++;
            $display("FAIL %s pc actual=%h expected=%h", tag, pc, exp_pc);
        end
        total++;
        if (stack_err !== exp_err) begin
            bad++;
            $display("FAIL %s stack_err actual=%b expected=%b", tag, stack_err, exp_err);
        end
    endtask

    // Bench model of one edge with the given inputs
    task automatic model(input logic [5:0] op, input logic [15:0] im, input logic z, input logic stp);
        logic [31:0] seq;
        if (!stp || m_halt) return;
        seq = m_pc + 32'd1;
        case (op)
            6'd6:  m_pc = zx(im);
            6'd7:  m_pc = m_pc + sx(im);
            6'd8:  m_pc = z ? zx(im) : seq;
            6'd9:  m_pc = z ? m_pc + sx(im) : seq;
            6'd10: m_pc = !z ? zx(im) : seq;
            6'd11: m_pc = !z ? m_pc + sx(im) : seq;
            6'd12: if (m_cnt == 8) m_err = 1'b1;
                   else begin m_stk[m_cnt] = seq; m_cnt++; m_pc = zx(im); end
            6'd13: if (m_cnt == 0) m_err = 1'b1;
                   else begin m_cnt--; m_pc = m_stk[m_cnt]; end
            6'd34: m_halt = 1'b1;
            default: m_pc = seq;
        endcase
    endtask

    // Apply one instruction at a falling edge, compare at the next falling edge
    task automatic do_step(input logic [5:0] op, input logic [15:0] im, input logic z, input logic stp);
        string tag;
        tag = tag_of(op, stp);
        if (m_halt) tag = "R10";
        opcode = op; imm = im; zero_flag = z; step = stp;
        @(posedge clk);
        model(op, im, z, stp);
        @(negedge clk);
        step = 1'b0;
        check(tag, m_pc, m_err);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step = 1'b0;
        halt_in = 1'b0;
        repeat (2) @(negedge clk);
        m_pc = '0; m_cnt = 0; m_err = 1'b0; m_halt = 1'b0;
        check("R1", 32'd0, 1'b0);
        rst_n = 1'b1;
    endtask

    function automatic logic [5:0] pick_op();
        int r;
        r = int'($urandom % 16);
        if (r < 10) return 6'(6 + (r % 8));
        if (r == 10) return 6'd33;
        begin
            logic [5:0] o;
            o = 6'($urandom % 64);
            if (o == 6'd34) o = 6'd35;
            return o;
        end
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // Directed: sequential, jumps, conditions (R3..R6, R12)
        do_step(6'd33, 16'h0, 1'b0, 1'b1);       // R12 nop advances
        do_step(6'd6, 16'hFFF0, 1'b0, 1'b1);     // R3 zero-extended
        do_step(6'd7, 16'h8000, 1'b0, 1'b1);     // R4 negative offset wraps
        do_step(6'd8, 16'h0100, 1'b0, 1'b1);     // R5 not taken
        do_step(6'd9, 16'h0004, 1'b1, 1'b1);     // R5 taken relative
        do_step(6'd10, 16'h0200, 1'b1, 1'b1);    // R6 not taken
        do_step(6'd11, 16'hFFFE, 1'b0, 1'b1);    // R6 taken relative back
        do_step(6'd6, 16'h1234, 1'b0, 1'b0);     // R2 no step

        // Directed: fill stack, overflow, LIFO unwind, underflow (R7, R8, R9)
        do_reset();
        for (int k = 0; k < 8; k++) do_step(6'd12, 16'(100 + 10 * k), 1'b0, 1'b1);
        do_step(6'd12, 16'h7777, 1'b0, 1'b1);    // R8 overflow
        for (int k = 0; k < 8; k++) do_step(6'd13, 16'h0, 1'b0, 1'b1); // R7 LIFO
        do_step(6'd13, 16'h0, 1'b0, 1'b1);       // R9 underflow
        do_step(6'd33, 16'h0, 1'b0, 1'b1);       // R9 error stays set

        // Directed: halt opcode (R10)
        do_reset();
        do_step(6'd7, 16'h0005, 1'b0, 1'b1);
        do_step(6'd34, 16'h0, 1'b0, 1'b1);
        do_step(6'd6, 16'h0077, 1'b0, 1'b1);     // R10 ignored
        do_step(6'd12, 16'h0010, 1'b0, 1'b1);    // R10 ignored

        // Directed: halt input (R11)
        do_reset();
        do_step(6'd6, 16'h0040, 1'b0, 1'b1);
        halt_in = 1'b1;
        step = 1'b1; opcode = 6'd6; imm = 16'h0099;
        @(posedge clk);
        m_halt = 1'b1;
        @(negedge clk);
        halt_in = 1'b0; step = 1'b0;
        check("R11", m_pc, m_err);
        do_step(6'd6, 16'h0055, 1'b0, 1'b1);
        check("R11", 32'h40, 1'b0);

        // Random phase
        do_reset();
        for (int n = 0; n < 2000; n++) begin
            logic stp;
            stp = ($urandom % 8) != 0;
            if (n % 400 == 399) do_reset();
            do_step(pick_op(), 16'($urandom), 1'($urandom), stp);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule